// File: doc/BRIEF.md
# Slack-Directed Memory Power-Mode Controller

This block sets the power mode of a small group of memory chips. Each chip has its own idle timer. The longer a chip goes without an access, the deeper the low-power mode it drops into: standby, then nap, then power-down. A chip wakes to active on its next access. Waking costs a fixed exit latency that depends on the mode the chip was in. The block adds that latency to a running delay total and raises a stall for that many cycles.

A slowdown budget bounds the total delay. On every epoch tick the budget grows by the allowed slowdown percentage times the predicted length of the coming epoch. The budget is kept in hundredths of a cycle, so no divider is needed. While the accumulated delay exceeds the budget, every chip is held active.

On the same tick a threshold scale factor is retuned. It grows when the budget was exhausted and shrinks when it was not. This factor stretches the nap and power-down thresholds. The standby threshold stays pinned at the break-even time.

Top module: `slack_pm_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every chip reports mode 00 (active) and `stall_o` is low. The scale factor starts at 256, which is 1.0 in unsigned Q8.8.
- R2: Mode codes are 00 active, 01 standby, 10 nap and 11 power-down, with chip i on `mode_o[2i+1:2i]`. An access to a chip, sampled at a clock edge, makes that chip report 00 after that edge and restarts its idle count from zero.
- R3: A chip whose idle count reached a threshold before an edge reports, after that edge, the deepest mode whose threshold it reached. The standby threshold is the fixed break-even count `TH_STBY`. The nap and power-down thresholds are `floor(BASE*C/256)`, raised to `TH_STBY` if they fall below it. Without an access or forcing, a chip's mode never becomes shallower.
- R4: An access to a chip that is not in 00 adds that mode's exit latency (`LAT_STBY`, `LAT_NAP` or `LAT_PDN`) to the delay total. Wakes in the same cycle add only the largest of their latencies. The delay total saturates.
- R5: After the edge that samples a wake, `stall_o` is high for exactly that wake's latency in cycles. Overlapping wakes keep the stall high until the later of their ends.
- R6: Each epoch tick adds `slowdown_pct_i * epoch_len_i` to the budget, counted in hundredths of a cycle. The budget saturates and never decreases.
- R7: At any edge where 100 times the new delay total exceeds the new budget, every chip reports 00 after that edge. All chips stay at 00 as long as that holds, and the condition is rechecked on every access and every tick.
- R8: On an epoch tick, if the chips were being held active, C becomes `min(2C, 2^C_W-1)`. Otherwise C becomes `floor(C*243/256)`, but never less than 1.
- R9: The idle count saturates at its maximum value, so a chip left idle indefinitely stays in the deepest mode it reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_i | input | N_CHIPS | Per-chip access strobe, one bit per chip |
| epoch_tick_i | input | 1 | One-cycle epoch boundary pulse |
| slowdown_pct_i | input | PCT_W | Allowed slowdown in percent for the coming epoch |
| epoch_len_i | input | LEN_W | Predicted length of the coming epoch in cycles |
| mode_o | output | 2*N_CHIPS | Per-chip power-mode codes |
| stall_o | output | 1 | High while a chip is waking up |

## Verification
The bench builds the block with three chips, an 8-bit idle count, a 10-bit scale factor and short thresholds (break-even 4, nap base 8, power-down base 16) and latencies (2, 5, 9). With these values, C saturation is reached in two doublings, and C shrinks to its floor within a couple of hundred ticks. The threshold clamp to break-even, where nap and power-down collapse onto one count, becomes reachable, as does idle-count saturation. A low slowdown percentage during the random phase keeps the budget tight enough that forcing and its release happen often. A budget of exactly 100 times the delay shows that equality does not force the chips active.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_STBY   = 2'b01,
    PM_NAP    = 2'b10,
    PM_PDN    = 2'b11
  } pm_mode_e;

  localparam int unsigned SCALE_FRAC = 8;
  localparam int unsigned SCALE_ONE  = 256;
  localparam int unsigned SHRINK_NUM = 243;
  localparam int unsigned PCT_DEN    = 100;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pm_scale_unit.sv
module pm_scale_unit
  import pm_ctrl_pkg::*;
#(
  parameter int unsigned C_W      = 16,
  parameter int unsigned TH_W     = 32,
  parameter int unsigned TH_STBY  = 8,
  parameter int unsigned NAP_BASE = 32,
  parameter int unsigned PDN_BASE = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            exhausted_i,
  output logic [C_W-1:0]  scale_o,
  output logic [TH_W-1:0] th_nap_o,
  output logic [TH_W-1:0] th_pdn_o
);
  localparam logic [C_W-1:0]  C_MAX  = '1;
  localparam logic [C_W-1:0]  C_MIN  = C_W'(1);
  localparam logic [TH_W-1:0] TH_LOW = TH_W'(TH_STBY);

  logic [C_W-1:0]  scale_q, scale_d, shrunk;
  logic [C_W:0]    doubled;
  logic [TH_W-1:0] nap_raw, pdn_raw;

  assign doubled = {scale_q, 1'b0};
  assign shrunk  = C_W'(((C_W+8)'(scale_q) * (C_W+8)'(SHRINK_NUM)) >> SCALE_FRAC);

  always_comb begin
    scale_d = scale_q;
    if (tick_i) begin
      if (exhausted_i) scale_d = doubled[C_W] ? C_MAX : doubled[C_W-1:0];
      else             scale_d = (shrunk == '0) ? C_MIN : shrunk;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scale_q <= C_W'(SCALE_ONE);
    else         scale_q <= scale_d;
  end

  assign nap_raw  = (TH_W'(NAP_BASE) * TH_W'(scale_q)) >> SCALE_FRAC;
  assign pdn_raw  = (TH_W'(PDN_BASE) * TH_W'(scale_q)) >> SCALE_FRAC;
  // deeper thresholds never undercut break-even
  assign th_nap_o = (nap_raw < TH_LOW) ? TH_LOW : nap_raw;
  assign th_pdn_o = (pdn_raw < TH_LOW) ? TH_LOW : pdn_raw;
  assign scale_o  = scale_q;
endmodule

// File: rtl/pm_chip_ctrl.sv
module pm_chip_ctrl
  import pm_ctrl_pkg::*;
#(
  parameter int unsigned IDLE_W   = 16,
  parameter int unsigned TH_W     = 32,
  parameter int unsigned TH_STBY  = 8,
  parameter int unsigned LAT_W    = 5,
  parameter int unsigned LAT_STBY = 2,
  parameter int unsigned LAT_NAP  = 6,
  parameter int unsigned LAT_PDN  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             access_i,
  input  logic             force_i,
  input  logic [TH_W-1:0]  th_nap_i,
  input  logic [TH_W-1:0]  th_pdn_i,
  output logic [1:0]       mode_o,
  output logic [LAT_W-1:0] wake_lat_o
);
  pm_mode_e          mode_q, mode_d, depth;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [TH_W-1:0]   idle_x;

  assign idle_x = TH_W'(idle_q);

  always_comb begin
    if      (idle_x >= th_pdn_i)          depth = PM_PDN;
    else if (idle_x >= th_nap_i)          depth = PM_NAP;
    else if (idle_x >= TH_W'(TH_STBY))    depth = PM_STBY;
    else                                  depth = PM_ACTIVE;
  end

  always_comb begin
    if (access_i || force_i) mode_d = PM_ACTIVE;
    else if (depth > mode_q) mode_d = depth;
    else                     mode_d = mode_q;
    if (access_i)       idle_d = '0;
    else if (&idle_q)   idle_d = idle_q;
    else                idle_d = idle_q + 1'b1;
  end

  always_comb begin
    wake_lat_o = '0;
    if (access_i) begin
      unique case (mode_q)
        PM_STBY:   wake_lat_o = LAT_W'(LAT_STBY);
        PM_NAP:    wake_lat_o = LAT_W'(LAT_NAP);
        PM_PDN:    wake_lat_o = LAT_W'(LAT_PDN);
        default:   wake_lat_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_ACTIVE;
      idle_q <= '0;
    end else begin
      mode_q <= mode_d;
      idle_q <= idle_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pm_slack_guard.sv
module pm_slack_guard
  import pm_ctrl_pkg::*;
#(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned LAT_W   = 5,
  parameter int unsigned DLY_W   = 24,
  parameter int unsigned PCT_W   = 7,
  parameter int unsigned LEN_W   = 24,
  parameter int unsigned ALW_W   = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CHIPS*LAT_W-1:0] wake_lat_i,
  input  logic                     tick_i,
  input  logic [PCT_W-1:0]         pct_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic                     force_d_o,
  output logic                     forced_o,
  output logic [ALW_W-1:0]         allow_o,
  output logic                     stall_o
);
  localparam int unsigned GR_W  = PCT_W + LEN_W;
  localparam int unsigned DX_W  = DLY_W + 7;
  localparam int unsigned CMP_W = ((ALW_W > DX_W) ? ALW_W : DX_W) + 1;

  logic [LAT_W-1:0] lat_max, stall_q, stall_d, stall_dec;
  logic [DLY_W-1:0] delay_q, delay_d;
  logic [DLY_W:0]   delay_sum;
  logic [ALW_W-1:0] allow_q, allow_d;
  logic [ALW_W:0]   allow_sum;
  logic [GR_W-1:0]  grant;
  logic             forced_q, forced_d;

  always_comb begin
    lat_max = '0;
    for (int i = 0; i < N_CHIPS; i++) begin
      if (wake_lat_i[i*LAT_W +: LAT_W] > lat_max) lat_max = wake_lat_i[i*LAT_W +: LAT_W];
    end
  end

  assign delay_sum = {1'b0, delay_q} + (DLY_W+1)'(lat_max);
  assign delay_d   = delay_sum[DLY_W] ? '1 : delay_sum[DLY_W-1:0];

  assign grant     = GR_W'(pct_i) * GR_W'(len_i);
  assign allow_sum = {1'b0, allow_q} + (ALW_W+1)'(grant);
  assign allow_d   = !tick_i ? allow_q : (allow_sum[ALW_W] ? '1 : allow_sum[ALW_W-1:0]);

  // budget held in hundredths of a cycle
  assign forced_d  = (CMP_W'(delay_d) * CMP_W'(PCT_DEN)) > CMP_W'(allow_d);

  assign stall_dec = (stall_q == '0) ? '0 : stall_q - 1'b1;
  assign stall_d   = (lat_max > stall_dec) ? lat_max : stall_dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q  <= '0;
      allow_q  <= '0;
      forced_q <= 1'b0;
      stall_q  <= '0;
    end else begin
      delay_q  <= delay_d;
      allow_q  <= allow_d;
      forced_q <= forced_d;
      stall_q  <= stall_d;
    end
  end

  assign force_d_o = forced_d;
  assign forced_o  = forced_q;
  assign allow_o   = allow_q;
  assign stall_o   = (stall_q != '0);
endmodule

// File: rtl/slack_pm_ctrl.sv
module slack_pm_ctrl
  import pm_ctrl_pkg::*;
#(
  parameter int unsigned N_CHIPS  = 4,
  parameter int unsigned IDLE_W   = 16,
  parameter int unsigned C_W      = 16,
  parameter int unsigned TH_STBY  = 8,
  parameter int unsigned NAP_BASE = 32,
  parameter int unsigned PDN_BASE = 128,
  parameter int unsigned LAT_STBY = 2,
  parameter int unsigned LAT_NAP  = 6,
  parameter int unsigned LAT_PDN  = 20,
  parameter int unsigned DLY_W    = 24,
  parameter int unsigned PCT_W    = 7,
  parameter int unsigned LEN_W    = 24,
  parameter int unsigned ALW_W    = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CHIPS-1:0]   access_i,
  input  logic                 epoch_tick_i,
  input  logic [PCT_W-1:0]     slowdown_pct_i,
  input  logic [LEN_W-1:0]     epoch_len_i,
  output logic [2*N_CHIPS-1:0] mode_o,
  output logic                 stall_o
);
  localparam int unsigned LAT_MAX = max3(LAT_STBY, LAT_NAP, LAT_PDN);
  localparam int unsigned LAT_W   = $clog2(LAT_MAX + 1);
  localparam int unsigned TH_W    = 16 + C_W;

  logic [TH_W-1:0]          th_nap, th_pdn;
  logic [C_W-1:0]           scale_q;
  logic [ALW_W-1:0]         allow_q;
  logic [N_CHIPS*LAT_W-1:0] wake_lat;
  logic                     forced_d, forced_q;

  pm_scale_unit #(
    .C_W(C_W), .TH_W(TH_W), .TH_STBY(TH_STBY),
    .NAP_BASE(NAP_BASE), .PDN_BASE(PDN_BASE)
  ) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(epoch_tick_i), .exhausted_i(forced_q),
    .scale_o(scale_q), .th_nap_o(th_nap), .th_pdn_o(th_pdn)
  );

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
    pm_chip_ctrl #(
      .IDLE_W(IDLE_W), .TH_W(TH_W), .TH_STBY(TH_STBY), .LAT_W(LAT_W),
      .LAT_STBY(LAT_STBY), .LAT_NAP(LAT_NAP), .LAT_PDN(LAT_PDN)
    ) u_chip (
      .clk_i(clk_i), .rst_ni(rst_ni), .access_i(access_i[g]), .force_i(forced_d),
      .th_nap_i(th_nap), .th_pdn_i(th_pdn),
      .mode_o(mode_o[2*g +: 2]), .wake_lat_o(wake_lat[g*LAT_W +: LAT_W])
    );
  end

  pm_slack_guard #(
    .N_CHIPS(N_CHIPS), .LAT_W(LAT_W), .DLY_W(DLY_W),
    .PCT_W(PCT_W), .LEN_W(LEN_W), .ALW_W(ALW_W)
  ) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .wake_lat_i(wake_lat), .tick_i(epoch_tick_i),
    .pct_i(slowdown_pct_i), .len_i(epoch_len_i),
    .force_d_o(forced_d), .forced_o(forced_q), .allow_o(allow_q), .stall_o(stall_o)
  );
endmodule

// File: rtl/slack_pm_ctrl_chk.sv
module slack_pm_ctrl_chk #(
  parameter int unsigned N_CHIPS = 4,
  parameter int unsigned C_W     = 16,
  parameter int unsigned ALW_W   = 40
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_CHIPS-1:0]   access_i,
  input logic                 epoch_tick_i,
  input logic [2*N_CHIPS-1:0] mode_o,
  input logic                 stall_o,
  input logic                 forced_q,
  input logic [C_W-1:0]       scale_q,
  input logic [ALW_W-1:0]     allow_q
);
  for (genvar g = 0; g < N_CHIPS; g++) begin : g_chk
    a_r2_access_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      access_i[g] |=> (mode_o[2*g +: 2] == 2'b00));
    a_r3_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !access_i[g] |=> ((mode_o[2*g +: 2] >= $past(mode_o[2*g +: 2])) || forced_q));
    a_r5_wake_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (access_i[g] && (mode_o[2*g +: 2] != 2'b00)) |=> stall_o);
  end

  a_r7_forced_all_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    forced_q |-> (mode_o == '0));
  a_r6_budget_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_tick_i |=> (allow_q == $past(allow_q)));
  a_r8_scale_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_q != '0);
  a_r8_shrink_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (epoch_tick_i && !forced_q) |=> (scale_q <= $past(scale_q)));
endmodule

bind slack_pm_ctrl slack_pm_ctrl_chk #(
  .N_CHIPS(N_CHIPS), .C_W(C_W), .ALW_W(ALW_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .access_i(access_i), .epoch_tick_i(epoch_tick_i),
  .mode_o(mode_o), .stall_o(stall_o), .forced_q(forced_q), .scale_q(scale_q),
  .allow_q(allow_q)
);

// File: tb/slack_pm_ctrl_tb.sv
module slack_pm_ctrl_tb;
  localparam int CLK_P    = 10;
  localparam int N        = 3;
  localparam int IDLE_W   = 8;
  localparam int C_W      = 10;
  localparam int TH_STBY  = 4;
  localparam int NAP_BASE = 8;
  localparam int PDN_BASE = 16;
  localparam int LS       = 2;
  localparam int LN       = 5;
  localparam int LP       = 9;
  localparam int DLY_W    = 12;
  localparam int PCT_W    = 7;
  localparam int LEN_W    = 10;
  localparam int ALW_W    = 24;
  localparam longint DMAX = (64'd1 << DLY_W) - 1;
  localparam longint AMAX = (64'd1 << ALW_W) - 1;
  localparam longint CMAX = (64'd1 << C_W) - 1;
  localparam int     IMAX = (1 << IDLE_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     acc;
  logic             tick;
  logic [PCT_W-1:0] pct;
  logic [LEN_W-1:0] len;
  logic [2*N-1:0]   mode;
  logic             stall;

  int     m_idle [N];
  int     m_mode [N];
  longint m_c, m_delay, m_allow;
  bit     m_forced;
  int     m_stall;
  int     total = 0, bad = 0;
  bit     done = 1'b0;

  slack_pm_ctrl #(
    .N_CHIPS(N), .IDLE_W(IDLE_W), .C_W(C_W), .TH_STBY(TH_STBY),
    .NAP_BASE(NAP_BASE), .PDN_BASE(PDN_BASE), .LAT_STBY(LS), .LAT_NAP(LN),
    .LAT_PDN(LP), .DLY_W(DLY_W), .PCT_W(PCT_W), .LEN_W(LEN_W), .ALW_W(ALW_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .access_i(acc), .epoch_tick_i(tick),
    .slowdown_pct_i(pct), .epoch_len_i(len), .mode_o(mode), .stall_o(stall)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic longint clamp_th(longint base);
    longint t;
    t = (base * m_c) / 256;
    return (t < TH_STBY) ? TH_STBY : t;
  endfunction

  function automatic int depth_of(int idle);
    if (idle >= clamp_th(PDN_BASE)) return 3;
    if (idle >= clamp_th(NAP_BASE)) return 2;
    if (idle >= TH_STBY)            return 1;
    return 0;
  endfunction

  function automatic int lat_of(int m);
    case (m)
      1: return LS;
      2: return LN;
      3: return LP;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_idle[i] = 0;
      m_mode[i] = 0;
    end
    m_c = 256; m_delay = 0; m_allow = 0; m_forced = 1'b0; m_stall = 0;
  endtask

  task automatic model_step(logic [N-1:0] a, bit t, int p, int l);
    int lmax, dec, d;
    longint nd, na, nc;
    bit nf;
    lmax = 0;
    for (int i = 0; i < N; i++)
      if (a[i] && m_mode[i] != 0 && lat_of(m_mode[i]) > lmax) lmax = lat_of(m_mode[i]);
    nd = m_delay + lmax;
    if (nd > DMAX) nd = DMAX;
    na = m_allow;
    if (t) begin
      na = na + longint'(p) * longint'(l);
      if (na > AMAX) na = AMAX;
    end
    nf = (nd * 100) > na;
    nc = m_c;
    if (t) begin
      if (m_forced) nc = (2 * m_c > CMAX) ? CMAX : 2 * m_c;
      else begin
        nc = (m_c * 243) / 256;
        if (nc == 0) nc = 1;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (a[i]) begin
        m_mode[i] = 0;
        m_idle[i] = 0;
      end else begin
        d = depth_of(m_idle[i]);
        if (nf) m_mode[i] = 0;
        else if (d > m_mode[i]) m_mode[i] = d;
        m_idle[i] = (m_idle[i] >= IMAX) ? IMAX : m_idle[i] + 1;
      end
    end
    dec = (m_stall > 0) ? m_stall - 1 : 0;
    m_stall = (lmax > dec) ? lmax : dec;
    m_delay = nd; m_allow = na; m_forced = nf; m_c = nc;
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic cyc(logic [N-1:0] a, bit t, int p, int l);
    acc = a; tick = t; pct = PCT_W'(p); len = LEN_W'(l);
    model_step(a, t, p, l);
    @(negedge clk);
    for (int i = 0; i < N; i++) chk("R3 mode vs model", mode[2*i +: 2], m_mode[i]);
    chk("R5 stall vs model", stall, (m_stall != 0) ? 1 : 0);
  endtask

  task automatic idle_n(int n);
    for (int k = 0; k < n; k++) cyc('0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; acc = '0; tick = 1'b0; pct = '0; len = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset modes", mode, 0);
    chk("R1 reset stall", stall, 0);
    rst_n = 1'b1;
    chk("R1 modes after release", mode, 0);

    // budget 200 hundredths, C -> 243
    cyc('0, 1'b1, 2, 100);
    idle_n(4);
    chk("R3 standby after break-even", mode[1:0], 1);
    cyc(3'b001, 1'b0, 0, 0);
    chk("R2 access returns to active", mode[1:0], 0);
    chk("R4 delay equal to budget does not force", mode[3:2], 1);
    chk("R5 stall after wake", stall, 1);
    cyc(3'b010, 1'b0, 0, 0);
    chk("R7 budget exceeded forces all active", mode, 0);
    cyc('0, 1'b0, 0, 0);
    chk("R5 stall second cycle", stall, 1);
    cyc('0, 1'b0, 0, 0);
    chk("R5 stall ends after latency", stall, 0);
    chk("R7 chips held active", mode, 0);

    // doubling to saturation while forced
    for (int k = 0; k < 3; k++) cyc('0, 1'b1, 0, 0);
    cyc('0, 1'b1, 100, 1000);
    cyc(3'b111, 1'b0, 0, 0);
    idle_n(31);
    chk("R8 saturated C stretches nap threshold", mode[1:0], 1);
    idle_n(1);
    chk("R8 nap at saturated threshold", mode[1:0], 2);

    // random phase with a tight budget
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] a;
      for (int i = 0; i < N; i++) a[i] = ($urandom % 12) == 0;
      if (($urandom % 100) == 0) cyc(a, 1'b1, int'($urandom % 4), int'($urandom % 256));
      else                       cyc(a, 1'b0, 0, 0);
    end

    // generous budget: C shrinks to its floor, idle saturates
    for (int k = 0; k < 200; k++) cyc('0, 1'b1, 100, 1000);
    idle_n(100);
    chk("R9 idle saturated keeps deepest mode", mode, 6'b111111);
    cyc(3'b001, 1'b0, 0, 0);
    idle_n(4);
    chk("R3 clamp not reached yet", mode[1:0], 0);
    idle_n(1);
    chk("R8 floored C collapses thresholds to break-even", mode[1:0], 3);
    chk("R6 budget keeps chips free", mode[5:2], 4'b1111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule